// File: doc/BRIEF.md
# Packet Page Allocator

This block hands out fixed 2 KB packet pages from a small pool and tracks who owns them. A one-bit-per-page ownership mask records which pages are in use. A software-visible command byte drives the page manager. Its top three bits select an operation: claim a page for transmit, wipe all allocation state, drop the oldest received page, drop it and free its page, free a named page, queue a named page for transmit, or empty the transmit queue. Every claim takes the lowest-numbered free page.

Two page-number queues sit beside the mask. The receive queue fills through a receive-side claim port whenever a frame may be taken in. The transmit queue fills through the queue command. A transmit claim that finds the pool exhausted reports code 0x80 and stays outstanding. The next page release then completes it in the same cycle, so software sees the claim finish without issuing it again. The block also reports the number of free pages and two interrupt-status bits: one for a granted transmit claim and one for pending receive data.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset, free_count equals the page count (4), alloc_result is 0, alloc_irq and rcv_irq are 0, rx_head is 0x80 (queue empty) and tx_count is 0.
- R2: Command code 1 claims the lowest-numbered free page. One clock later alloc_result holds that page number, alloc_irq is 1 and free_count has dropped by one.
- R3: Command code 1 with no free page sets alloc_result to 0x80 and clears alloc_irq.
- R4: While alloc_result is 0x80, any page release (code 4 with a non-empty receive queue, or code 5) grants the freed page at once. alloc_result becomes that page, alloc_irq is set and free_count stays unchanged.
- R5: free_count always equals the number of unallocated pages.
- R6: rx_ready is 1 exactly when rx_enable is 1, rx_soft_rst is 0, a page is free and the receive queue holds fewer than 4 entries. An accepted rx_alloc_req claims the lowest free page (shown on rx_page), appends it to the receive queue and sets rcv_irq.
- R7: Code 3 removes the receive queue head and leaves the queue untouched when it is empty. Afterwards rcv_irq is 1 when entries remain and 0 otherwise. rx_head shows the head page, or 0x80 when the queue is empty.
- R8: Code 4 frees the head page only if the receive queue is non-empty, then pops exactly as code 3 does.
- R9: Code 5 frees the page given on pkt_num.
- R10: Code 6 appends pkt_num to the transmit queue (head on tx_head). It is ignored when the queue already holds 4 entries.
- R11: Code 7 empties the transmit queue and leaves page ownership unchanged.
- R12: Code 2 frees every page, empties both queues and sets alloc_result to 0 (no claim outstanding). It leaves alloc_irq and rcv_irq as they were.
- R13: Only cmd_byte bits 7:5 select the operation. Bits 4:0 are ignored, and code 0 changes nothing.
- R14: A command cycle takes precedence: rx_alloc_req is not accepted while cmd_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte is written this cycle |
| cmd_byte | input | 8 | Command byte; bits 7:5 are the operation |
| pkt_num | input | PW | Page named by release and queue commands |
| rx_enable | input | 1 | Receive path enabled |
| rx_soft_rst | input | 1 | Receive path held in soft reset |
| rx_alloc_req | input | 1 | Receive side asks for a page |
| rx_ready | output | 1 | A receive claim would be accepted |
| rx_accept | output | 1 | Receive claim taken this cycle |
| rx_page | output | PW | Page given to the receive side when accepted |
| alloc_result | output | 8 | Last transmit claim result, 0x80 if failed |
| alloc_irq | output | 1 | Transmit claim granted status bit |
| rcv_irq | output | 1 | Receive data pending status bit |
| free_count | output | CW | Number of unallocated pages |
| rx_head | output | 8 | Receive queue head page, 0x80 if empty |
| tx_head | output | PW | Transmit queue head page |
| tx_count | output | CW | Transmit queue occupancy |

## Verification
Every command and every accepted receive claim updates registered state. The new values of alloc_result, the irq bits, free_count, rx_head and tx_count are therefore due one clock after the edge that samples the stimulus. rx_ready and rx_page are combinational from that state and from the enable inputs, so they are valid within the same cycle. The bench drives inputs on the falling edge and removes them on the next falling edge. It reads registered results at that second falling edge, one rising edge after the command. It reads rx_ready shortly after changing the enable inputs.

// File: rtl/pkt_alloc_pkg.sv
// Shared operation codes and constants for the packet page allocator.
package pkt_alloc_pkg;

    // Operation selected by command byte bits 7:5.
    typedef enum logic [2:0] {
        OP_NOP         = 3'd0,
        OP_TX_CLAIM    = 3'd1,
        OP_WIPE        = 3'd2,
        OP_RX_DROP     = 3'd3,
        OP_RX_DROP_REL = 3'd4,
        OP_RELEASE     = 3'd5,
        OP_TX_QUEUE    = 3'd6,
        OP_TX_FLUSH    = 3'd7
    } mmu_op_e;

    // Result code for a claim that found no free page.
    localparam logic [7:0] CLAIM_FAIL = 8'h80;

endpackage

// File: rtl/page_pool.sv
// Page ownership mask.
// Finds the lowest free page, counts free pages, and applies one release
// and one claim per cycle. The release is applied before the claim, so the
// same page may be freed and claimed again in one cycle.
// Assumes the claim index names a free page, or the page being released.
module page_pool #(
    parameter int NUM_PAGES = 4,
    localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int CW = $clog2(NUM_PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic          rel_en,
    input  logic [PW-1:0] rel_idx,
    input  logic          claim_en,
    input  logic [PW-1:0] claim_idx,
    output logic          any_free,
    output logic [PW-1:0] lowest_free,
    output logic [CW-1:0] free_count
);

    logic [NUM_PAGES-1:0] used_q;
    logic [NUM_PAGES-1:0] used_d;

    // Priority search: lowest index with a clear ownership bit.
    always_comb begin
        lowest_free = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (!used_q[i]) lowest_free = PW'(i);
        end
    end

    // Population count of free pages.
    always_comb begin
        free_count = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (!used_q[i]) free_count = free_count + CW'(1);
        end
    end

    assign any_free = ~&used_q;

    // Next mask: release first, then claim.
    always_comb begin
        used_d = used_q;
        if (rel_en)   used_d[rel_idx]   = 1'b0;
        if (claim_en) used_d[claim_idx] = 1'b1;
        if (wipe)     used_d            = '0;
    end

    // Ownership register.
    always_ff @(posedge clk) begin
        if (!rst_n) used_q <= '0;
        else        used_q <= used_d;
    end

endmodule

// File: rtl/page_fifo.sv
// Circular queue of page numbers with clear, push and pop.
// A push to a full queue and a pop from an empty one are dropped here, so
// callers may gate them or not. Push and pop may occur in the same cycle.
module page_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 2,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [DW-1:0] slots_q [DEPTH];
    logic [AW-1:0] rd_q;
    logic [AW-1:0] wr_q;
    logic          do_push;
    logic          do_pop;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign head    = slots_q[rd_q];
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_q  <= '0;
            wr_q  <= '0;
            count <= '0;
        end else begin
            if (do_pop)  rd_q <= bump(rd_q);
            if (do_push) wr_q <= bump(wr_q);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    // Slot storage, written at the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
        end else if (do_push) begin
            slots_q[wr_q] <= push_data;
        end
    end

endmodule

// File: rtl/pkt_page_alloc.sv
// Packet page allocator top.
// Decodes the command byte, owns the transmit-claim result and the two
// status bits, and arbitrates the receive-side claim port against commands.
// Assumes at most one command per cycle; a command cycle blocks the
// receive claim. NUM_PAGES must stay below 128 so page numbers never
// collide with the 0x80 failure code.
module pkt_page_alloc
    import pkt_alloc_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int CW = $clog2(NUM_PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_byte,
    input  logic [PW-1:0] pkt_num,
    input  logic          rx_enable,
    input  logic          rx_soft_rst,
    input  logic          rx_alloc_req,
    output logic          rx_ready,
    output logic          rx_accept,
    output logic [PW-1:0] rx_page,
    output logic [7:0]    alloc_result,
    output logic          alloc_irq,
    output logic          rcv_irq,
    output logic [CW-1:0] free_count,
    output logic [7:0]    rx_head,
    output logic [PW-1:0] tx_head,
    output logic [CW-1:0] tx_count
);

    mmu_op_e       op;
    logic          cmd_low_unused;
    logic          any_free;
    logic [PW-1:0] lowest_free;
    logic          wipe;
    logic          rel_en;
    logic [PW-1:0] rel_idx;
    logic          claim_en;
    logic [PW-1:0] claim_idx;
    logic          pending;
    logic          retry;
    logic          tx_claim;
    logic          rx_pop;
    logic [PW-1:0] rx_head_idx;
    logic [CW-1:0] rx_count;
    logic          rx_empty;
    logic          rx_full;
    logic          tx_push;
    logic          tx_clear;
    logic          tx_empty;
    logic          tx_full;

    assign op             = cmd_valid ? mmu_op_e'(cmd_byte[7:5]) : OP_NOP;
    assign cmd_low_unused = ^cmd_byte[4:0];
    assign pending        = (alloc_result == CLAIM_FAIL);

    // Receive-side claim gating.
    assign rx_ready  = rx_enable && !rx_soft_rst && any_free && !rx_full;
    assign rx_accept = rx_alloc_req && rx_ready && !cmd_valid;
    assign rx_page   = lowest_free;

    // Release source: head of receive queue or the named page.
    always_comb begin
        rel_en  = 1'b0;
        rel_idx = pkt_num;
        if (op == OP_RX_DROP_REL && !rx_empty) begin
            rel_en  = 1'b1;
            rel_idx = rx_head_idx;
        end else if (op == OP_RELEASE) begin
            rel_en = 1'b1;
        end
    end

    // An outstanding failed claim is completed by any release.
    assign retry    = rel_en && pending;
    assign tx_claim = (op == OP_TX_CLAIM) && any_free;

    // Claim source: retry takes the released page, others the lowest free.
    always_comb begin
        claim_en  = retry || tx_claim || rx_accept;
        claim_idx = retry ? rel_idx : lowest_free;
    end

    assign wipe     = (op == OP_WIPE);
    assign rx_pop   = (op == OP_RX_DROP) || (op == OP_RX_DROP_REL);
    assign tx_push  = (op == OP_TX_QUEUE) && !tx_full;
    assign tx_clear = wipe || (op == OP_TX_FLUSH);

    page_pool #(.NUM_PAGES(NUM_PAGES)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .wipe       (wipe),
        .rel_en     (rel_en),
        .rel_idx    (rel_idx),
        .claim_en   (claim_en),
        .claim_idx  (claim_idx),
        .any_free   (any_free),
        .lowest_free(lowest_free),
        .free_count (free_count)
    );

    page_fifo #(.DEPTH(NUM_PAGES), .DW(PW)) u_rx_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (wipe),
        .push     (rx_accept),
        .push_data(lowest_free),
        .pop      (rx_pop),
        .head     (rx_head_idx),
        .count    (rx_count),
        .empty    (rx_empty),
        .full     (rx_full)
    );

    page_fifo #(.DEPTH(NUM_PAGES), .DW(PW)) u_tx_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tx_clear),
        .push     (tx_push),
        .push_data(pkt_num),
        .pop      (1'b0),
        .head     (tx_head),
        .count    (tx_count),
        .empty    (tx_empty),
        .full     (tx_full)
    );

    assign rx_head = rx_empty ? CLAIM_FAIL : 8'(rx_head_idx);

    // Transmit-claim result and its status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_result <= '0;
            alloc_irq    <= 1'b0;
        end else if (wipe) begin
            alloc_result <= '0;
        end else if (op == OP_TX_CLAIM) begin
            alloc_result <= any_free ? 8'(lowest_free) : CLAIM_FAIL;
            alloc_irq    <= any_free;
        end else if (retry) begin
            alloc_result <= 8'(rel_idx);
            alloc_irq    <= 1'b1;
        end
    end

    // Receive-pending status bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         rcv_irq <= 1'b0;
        else if (rx_pop)    rcv_irq <= (rx_count > CW'(1));
        else if (rx_accept) rcv_irq <= 1'b1;
    end

endmodule

// File: rtl/pkt_page_alloc_chk.sv
// Property checker for the packet page allocator, bound to the top module.
// Observes ports only.
module pkt_page_alloc_chk #(
    parameter int NUM_PAGES = 4,
    localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int CW = $clog2(NUM_PAGES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [7:0]    cmd_byte,
    input logic [PW-1:0] pkt_num,
    input logic          rx_enable,
    input logic          rx_soft_rst,
    input logic          rx_alloc_req,
    input logic          rx_ready,
    input logic          rx_accept,
    input logic [PW-1:0] rx_page,
    input logic [7:0]    alloc_result,
    input logic          alloc_irq,
    input logic          rcv_irq,
    input logic [CW-1:0] free_count,
    input logic [7:0]    rx_head,
    input logic [PW-1:0] tx_head,
    input logic [CW-1:0] tx_count
);

    logic [2:0] opc;
    assign opc = cmd_byte[7:5];

    assert_claim_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && opc == 3'd1 && free_count == '0 |=> alloc_result == 8'h80 && !alloc_irq);

    assert_claim_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && opc == 3'd1 && free_count != '0 |=> alloc_irq && free_count == $past(free_count) - CW'(1));

    assert_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && opc == 3'd5 && alloc_result == 8'h80 |=> alloc_result == 8'($past(pkt_num)) && alloc_irq && $stable(free_count));

    assert_free_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        free_count <= CW'(NUM_PAGES));

    assert_rx_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rx_enable && !rx_soft_rst && free_count != '0);

    assert_rx_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept && rx_head == 8'h80 |=> rx_head == 8'($past(rx_page)) && rcv_irq);

    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && opc == 3'd3 && rx_head == 8'h80 |=> rx_head == 8'h80 && !rcv_irq);

    assert_tx_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && opc == 3'd6 && tx_count == '0 |=> tx_head == $past(pkt_num) && tx_count == CW'(1));

    assert_tx_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && opc == 3'd6 && tx_count == CW'(NUM_PAGES) |=> tx_count == CW'(NUM_PAGES));

    assert_wipe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && opc == 3'd2 |=> free_count == CW'(NUM_PAGES) && tx_count == '0 && rx_head == 8'h80 && alloc_result == 8'h00);

    assert_nop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && opc == 3'd0 |=> $stable(free_count) && $stable(tx_count) && $stable(alloc_result) && $stable(rx_head));

    assert_cmd_first_R14: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |-> rx_alloc_req && rx_ready && !cmd_valid);

endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (.*);

// File: tb/pkt_page_alloc_tb.sv
// Directed bench for the packet page allocator: one task per scenario.
module pkt_page_alloc_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic [1:0] pkt_num = '0;
    logic       rx_enable = 1'b0;
    logic       rx_soft_rst = 1'b0;
    logic       rx_alloc_req = 1'b0;
    logic       rx_ready;
    logic       rx_accept;
    logic [1:0] rx_page;
    logic [7:0] alloc_result;
    logic       alloc_irq;
    logic       rcv_irq;
    logic [2:0] free_count;
    logic [7:0] rx_head;
    logic [1:0] tx_head;
    logic [2:0] tx_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pkt_page_alloc #(.NUM_PAGES(4)) u_dut (.*);

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Issue one command; returns one rising edge later, at a falling edge.
    task automatic cmd(input logic [2:0] code, input logic [1:0] page, input logic [4:0] low);
        cmd_valid = 1'b1;
        cmd_byte  = {code, low};
        pkt_num   = page;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_byte  = '0;
    endtask

    // Hold the receive claim request for n cycles.
    task automatic rx_claim(input int n);
        rx_alloc_req = 1'b1;
        repeat (n) @(negedge clk);
        rx_alloc_req = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 free", free_count, 4);
        check("R1 result", alloc_result, 0);
        check("R1 alloc_irq", alloc_irq, 0);
        check("R1 rcv_irq", rcv_irq, 0);
        check("R1 rx_head", rx_head, 8'h80);
        check("R1 tx_count", tx_count, 0);
    endtask

    task automatic t_claims;
        for (int i = 0; i < 4; i++) begin
            cmd(3'd1, 2'd0, 5'd0);
            check("R2 lowest page", alloc_result, i);
            check("R2 alloc_irq", alloc_irq, 1);
            check("R5 free", free_count, 3 - i);
        end
        cmd(3'd1, 2'd0, 5'd0);
        check("R3 fail code", alloc_result, 8'h80);
        check("R3 alloc_irq cleared", alloc_irq, 0);
        cmd(3'd5, 2'd2, 5'd0);
        check("R4 retry page", alloc_result, 2);
        check("R4 retry irq", alloc_irq, 1);
        check("R4 free unchanged", free_count, 0);
        cmd(3'd5, 2'd1, 5'd0);
        check("R9 release frees", free_count, 1);
        check("R9 result kept", alloc_result, 2);
        cmd(3'd1, 2'd0, 5'd0);
        check("R2 reuse lowest", alloc_result, 1);
        cmd(3'd2, 2'd0, 5'd0);
        check("R12 free all", free_count, 4);
        check("R12 result zero", alloc_result, 0);
        check("R12 irq kept", alloc_irq, 1);
    endtask

    task automatic t_receive;
        rx_enable = 1'b1;
        #1 check("R6 ready", rx_ready, 1);
        rx_soft_rst = 1'b1;
        #1 check("R6 soft reset blocks", rx_ready, 0);
        rx_soft_rst = 1'b0;
        @(negedge clk);
        rx_alloc_req = 1'b1;
        cmd(3'd0, 2'd0, 5'd0);
        rx_alloc_req = 1'b0;
        check("R14 blocked by cmd", rx_head, 8'h80);
        check("R14 free", free_count, 4);
        rx_claim(1);
        check("R6 head page", rx_head, 0);
        check("R6 rcv_irq", rcv_irq, 1);
        rx_claim(1);
        check("R6 second claim", free_count, 2);
        cmd(3'd1, 2'd0, 5'd0);
        check("R2 after rx", alloc_result, 2);
        cmd(3'd3, 2'd0, 5'd0);
        check("R7 head advances", rx_head, 1);
        check("R7 rcv kept", rcv_irq, 1);
        check("R7 pop keeps page", free_count, 1);
        cmd(3'd4, 2'd0, 5'd0);
        check("R8 release head", free_count, 2);
        check("R8 queue empty", rx_head, 8'h80);
        check("R8 rcv cleared", rcv_irq, 0);
        cmd(3'd4, 2'd0, 5'd0);
        check("R8 empty no release", free_count, 2);
        cmd(3'd3, 2'd0, 5'd0);
        check("R7 empty pop", rx_head, 8'h80);
        check("R7 empty rcv", rcv_irq, 0);
        cmd(3'd2, 2'd0, 5'd0);
        rx_claim(4);
        check("R6 pool drained", free_count, 0);
        check("R6 not ready", rx_ready, 0);
        rx_claim(1);
        check("R6 extra ignored", rx_head, 0);
        cmd(3'd1, 2'd0, 5'd0);
        check("R3 fail after rx", alloc_result, 8'h80);
        cmd(3'd4, 2'd0, 5'd0);
        check("R4 retry via rx release", alloc_result, 0);
        check("R4 free", free_count, 0);
        check("R8 next head", rx_head, 1);
        check("R7 rcv remains", rcv_irq, 1);
        rx_enable = 1'b0;
        #1 check("R6 disabled", rx_ready, 0);
    endtask

    task automatic t_transmit;
        cmd(3'd2, 2'd0, 5'd0);
        cmd(3'd6, 2'd3, 5'h15);
        check("R10 first entry", tx_head, 3);
        check("R13 low bits ignored", tx_count, 1);
        cmd(3'd6, 2'd1, 5'h0a);
        cmd(3'd6, 2'd0, 5'd0);
        cmd(3'd6, 2'd2, 5'd0);
        check("R10 count", tx_count, 4);
        cmd(3'd6, 2'd1, 5'd0);
        check("R10 full ignored", tx_count, 4);
        check("R10 head kept", tx_head, 3);
        cmd(3'd0, 2'd1, 5'h1f);
        check("R13 nop count", tx_count, 4);
        check("R13 nop free", free_count, 4);
        check("R13 nop result", alloc_result, 0);
        cmd(3'd7, 2'd0, 5'd0);
        check("R11 flushed", tx_count, 0);
        check("R11 pages kept", free_count, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_claims;
        t_receive;
        t_transmit;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule